// File: doc/BRIEF.md
# Power Island Handshake Sequencer

This block switches one power island on and off. A register write starts a command. The block then runs a fixed handshake with the island's bus interface, so that no traffic is in flight when the supply is cut. To power down, it first asks the bus interface to go quiet and waits for an acknowledge and an idle indication. Only then does it open the power switch. To power up, it closes the switch and waits for the island to report power. It then withdraws the quiet request and waits for the acknowledge and the idle indication to clear.

The acknowledge, idle and power-status inputs come from other clock domains. Each passes through a two-flop synchronizer before the state machine looks at it. Each wait step has a cycle limit; when the limit runs out, the block enters an error state and records which step failed. Two settle counts are programmed separately, one for power-down and one for power-up. After the switch moves, the block waits the relevant count before it looks at the power status. A build-time variant serves islands that have no power status line; in that variant the island's state is read from its idle indication.

Top module: `pd_seq`

## Requirements
- R1: A power-off command raises `idle_req_o` first. The block then waits for the synchronized acknowledge and then for the synchronized idle indication. Only after both does `pwr_en_o` fall.
- R2: A power-on command raises `pwr_en_o` first. The block waits for the power status to report on. Only then does `idle_req_o` fall. The block then waits for the acknowledge to clear and for the idle indication to clear before it signals completion.
- R3: `pwr_stat_i` = 0 means the island is powered and 1 means it is off. STATUS (byte address 0x4) bit 1 reads 1 when the island is powered.
- R4: With `HAS_STATUS` = 0, the powered state is taken as the inverse of the synchronized `idle_i`. STATUS bit 1 then reads the inverse of `idle_i`.
- R5: CTRL (byte address 0x0) uses masked writes: write bit 16 enables bit 0, and write bit 17 enables bit 1. A write whose bit 16 is set issues a command: bit 0 = 1 means power on, 0 means power off. Bit 0 reads back the last accepted target. A write with bit 16 clear issues no command and leaves that bit unchanged.
- R6: Each wait step lasts at most `TO_CYCLES` cycles. On expiry, `timeout_o` rises and stays high until the next accepted command. STATUS bits [5:4] give the failed step: 1 = acknowledge, 2 = idle, 3 = power status. A command clears the code to 0.
- R7: The power-down settle count is at 0x8 and the power-up settle count at 0xC; both reset to 24. After `pwr_en_o` changes, the block waits count+1 cycles before it samples the power status. With the status already valid, the next output step therefore follows count+2 cycles after the switch edge: `done_o` for power-off, the fall of `idle_req_o` for power-on.
- R8: A command whose target equals the current powered state completes with a `done_o` pulse. Neither `pwr_en_o` nor `idle_req_o` changes.
- R9: A command written while `busy_o` is high is ignored, including during the cycle in which `done_o` is high. It sets a sticky overrun flag at STATUS bit 2, which is cleared only by a CTRL write with bits 17 and 1 both set.
- R10: After reset, `pwr_en_o` = 1, `idle_req_o` = 0, and `busy_o`, `done_o` and `timeout_o` are 0. `busy_o` stays high from the cycle after a command is accepted until completion, and `done_o` is a one-cycle pulse. STATUS bit 0 mirrors `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| ack_i | input | 1 | Idle acknowledge from island bus interface (asynchronous) |
| idle_i | input | 1 | Idle indication from island bus interface (asynchronous) |
| pwr_stat_i | input | 1 | Power status, 1 = off (asynchronous) |
| pwr_en_o | output | 1 | Power switch enable, 1 = powered |
| idle_req_o | output | 1 | Bus idle request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | A wait step expired |

## Verification
Completion and a new command can fall in the same cycle. The last state of a sequence is still busy, so a command written then has to be refused and flagged as an overrun. The bench provokes this by sampling `done_o` at the falling edge and issuing a reversing command at that very moment, so that the write lands on the edge that ends the done cycle. It judges the result three ways. The scoreboard must see no further switch or request movement. The powered state must stay at the completed target. STATUS bit 2 must read 1.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int ADDR_W = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DOWN = 2'd2;
  localparam logic [1:0] SEL_UP   = 2'd3;

  typedef enum logic [10:0] {
    ST_IDLE          = 11'h001,
    ST_REQ_IDLE      = 11'h002,
    ST_WAIT_ACK      = 11'h004,
    ST_WAIT_IDLE     = 11'h008,
    ST_PWR_SWITCH    = 11'h010,
    ST_WAIT_PWR      = 11'h020,
    ST_REL_IDLE      = 11'h040,
    ST_WAIT_ACK_CLR  = 11'h080,
    ST_WAIT_IDLE_CLR = 11'h100,
    ST_DONE          = 11'h200,
    ST_ERROR         = 11'h400
  } state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_ACK  = 2'd1,
    ERR_IDLE = 2'd2,
    ERR_PWR  = 2'd3
  } err_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/pd_regs.sv
module pd_regs
  import pd_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_CNT = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              on_i,
  input  err_e              err_i,
  output logic              cmd_vld_o,
  output logic              cmd_on_o,
  output logic [CNT_W-1:0]  down_cnt_o,
  output logic [CNT_W-1:0]  up_cnt_o
);
  logic [1:0]       sel;
  logic             ctrl_wr, cmd_try, ovr_set, ovr_clr;
  logic             tgt_q, ovr_q;
  logic [CNT_W-1:0] down_q, up_q;
  logic             unused_bits;

  assign sel         = addr_i[3:2];
  assign ctrl_wr     = we_i && (sel == SEL_CTRL);
  assign cmd_try     = ctrl_wr && wdata_i[16];
  assign cmd_vld_o   = cmd_try && !busy_i;
  assign cmd_on_o    = wdata_i[0];
  assign ovr_set     = cmd_try && busy_i;
  assign ovr_clr     = ctrl_wr && wdata_i[17] && wdata_i[1];
  assign unused_bits = ^{wdata_i[31:18], addr_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= 1'b1;
      ovr_q  <= 1'b0;
      down_q <= CNT_W'(RST_CNT);
      up_q   <= CNT_W'(RST_CNT);
    end else begin
      if (cmd_vld_o) tgt_q <= wdata_i[0];
      if (ovr_set) ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
      if (we_i && sel == SEL_DOWN) down_q <= wdata_i[CNT_W-1:0];
      if (we_i && sel == SEL_UP)   up_q   <= wdata_i[CNT_W-1:0];
    end
  end

  assign down_cnt_o = down_q;
  assign up_cnt_o   = up_q;

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata_o = {31'd0, tgt_q};
      SEL_STAT: rdata_o = {26'd0, err_i, 1'b0, ovr_q, on_i, busy_i};
      SEL_DOWN: rdata_o = 32'(down_q);
      default:  rdata_o = 32'(up_q);
    endcase
  end

  p_mask_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[16]) |=> $stable(tgt_q));
  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr) |=> ovr_q);
  p_busy_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_try && busy_i) |=> (ovr_q && $stable(tgt_q)));
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TO_CYCLES  = 500000,
  parameter bit HAS_STATUS = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  logic             cmd_on_i,
  input  logic [CNT_W-1:0] down_cnt_i,
  input  logic [CNT_W-1:0] up_cnt_i,
  input  logic             ack_s_i,
  input  logic             idle_s_i,
  input  logic             stat_s_i,
  output logic             pwr_en_o,
  output logic             idle_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic             on_o,
  output err_e             err_o
);
  localparam int TO_W = $clog2(TO_CYCLES + 1);

  state_e           state_q, state_d;
  logic             dir_q, dir_d, pwr_q, req_q, on_s, pwr_ok, to_hit, idle_st;
  logic [CNT_W-1:0] cnt_q;
  logic [TO_W-1:0]  to_q;
  err_e             err_q;

  if (HAS_STATUS) begin : g_stat
    assign on_s   = !stat_s_i;
    assign pwr_ok = (on_s == dir_q);
  end else begin : g_idle_only
    assign on_s   = !idle_s_i;
    assign pwr_ok = 1'b1;
  end

  assign idle_st = (state_q == ST_IDLE) || (state_q == ST_ERROR);
  assign to_hit  = (to_q == TO_W'(TO_CYCLES - 1));
  assign dir_d   = (idle_st && cmd_vld_i) ? cmd_on_i : dir_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_ERROR:
        if (cmd_vld_i) begin
          if (cmd_on_i == on_s) state_d = ST_DONE;
          else if (cmd_on_i)    state_d = ST_PWR_SWITCH;
          else                  state_d = ST_REQ_IDLE;
        end
      ST_REQ_IDLE:      state_d = ST_WAIT_ACK;
      ST_WAIT_ACK:      if (ack_s_i) state_d = ST_WAIT_IDLE;
                        else if (to_hit) state_d = ST_ERROR;
      ST_WAIT_IDLE:     if (idle_s_i) state_d = ST_PWR_SWITCH;
                        else if (to_hit) state_d = ST_ERROR;
      ST_PWR_SWITCH:    if (cnt_q == '0) state_d = ST_WAIT_PWR;
      ST_WAIT_PWR:      if (pwr_ok) state_d = dir_q ? ST_REL_IDLE : ST_DONE;
                        else if (to_hit) state_d = ST_ERROR;
      ST_REL_IDLE:      state_d = ST_WAIT_ACK_CLR;
      ST_WAIT_ACK_CLR:  if (!ack_s_i) state_d = ST_WAIT_IDLE_CLR;
                        else if (to_hit) state_d = ST_ERROR;
      ST_WAIT_IDLE_CLR: if (!idle_s_i) state_d = ST_DONE;
                        else if (to_hit) state_d = ST_ERROR;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b1;
      pwr_q   <= 1'b1;
      req_q   <= 1'b0;
      cnt_q   <= '0;
      to_q    <= '0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      if (state_d != state_q) to_q <= '0;
      else if (!to_hit) to_q <= to_q + 1'b1;
      if (state_d == ST_PWR_SWITCH && state_q != ST_PWR_SWITCH) begin
        pwr_q <= dir_d;
        cnt_q <= dir_d ? up_cnt_i : down_cnt_i;
      end else if (state_q == ST_PWR_SWITCH && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (state_d == ST_REQ_IDLE) req_q <= 1'b1;
      if (state_d == ST_REL_IDLE) req_q <= 1'b0;
      if (idle_st && cmd_vld_i) err_q <= ERR_NONE;
      else if (state_d == ST_ERROR && state_q != ST_ERROR) begin
        unique case (state_q)
          ST_WAIT_ACK, ST_WAIT_ACK_CLR:   err_q <= ERR_ACK;
          ST_WAIT_IDLE, ST_WAIT_IDLE_CLR: err_q <= ERR_IDLE;
          default:                        err_q <= ERR_PWR;
        endcase
      end
    end
  end

  assign pwr_en_o   = pwr_q;
  assign idle_req_o = req_q;
  assign busy_o     = !idle_st;
  assign done_o     = (state_q == ST_DONE);
  assign timeout_o  = (state_q == ST_ERROR);
  assign on_o       = on_s;
  assign err_o      = err_q;

  p_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);
  p_off_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_q) |-> (req_q && $past(idle_s_i)));
  p_on_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> (pwr_q && (!HAS_STATUS || $past(on_s))));
  p_err_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (err_q != ERR_NONE));
  p_err_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !cmd_vld_i) |=> timeout_o);
  p_settle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWR_SWITCH && cnt_q != '0) |=> (state_q == ST_PWR_SWITCH));
  p_same_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_st && cmd_vld_i && cmd_on_i == on_s) |=>
      (done_o && $stable(pwr_q) && $stable(req_q)));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_CNT    = 24,
  parameter int TO_CYCLES  = 500000,
  parameter bit HAS_STATUS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ack_i,
  input  logic              idle_i,
  input  logic              pwr_stat_i,
  output logic              pwr_en_o,
  output logic              idle_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  logic [2:0]       sync_q;
  logic             cmd_vld, cmd_on, on_s;
  logic [CNT_W-1:0] down_cnt, up_cnt;
  err_e             err;

  pd_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pwr_stat_i, idle_i, ack_i}),
    .q_o   (sync_q)
  );

  pd_regs #(.CNT_W(CNT_W), .RST_CNT(RST_CNT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy_o),
    .on_i      (on_s),
    .err_i     (err),
    .cmd_vld_o (cmd_vld),
    .cmd_on_o  (cmd_on),
    .down_cnt_o(down_cnt),
    .up_cnt_o  (up_cnt)
  );

  pd_fsm #(.CNT_W(CNT_W), .TO_CYCLES(TO_CYCLES), .HAS_STATUS(HAS_STATUS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_vld_i (cmd_vld),
    .cmd_on_i  (cmd_on),
    .down_cnt_i(down_cnt),
    .up_cnt_i  (up_cnt),
    .ack_s_i   (sync_q[0]),
    .idle_s_i  (sync_q[1]),
    .stat_s_i  (sync_q[2]),
    .pwr_en_o  (pwr_en_o),
    .idle_req_o(idle_req_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .on_o      (on_s),
    .err_o     (err)
  );
endmodule

// File: tb/pd_seq_tb.sv
module pd_seq_tb;
  localparam int EV_REQ_UP = 1, EV_REQ_DN = 2, EV_PWR_DN = 3, EV_PWR_UP = 4,
                 EV_DONE = 5, EV_TMO = 6;
  localparam logic [31:0] OFF_CMD = 32'h0001_0000, ON_CMD = 32'h0001_0001;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [31:0] wdata = '0, rdata, io_rdata;
  logic ack_i = 1'b0, idle_i = 1'b0, pwr_stat_i = 1'b0, io_idle = 1'b0;
  logic pwr_en_o, idle_req_o, busy_o, done_o, timeout_o;
  logic io_pwr, io_req, io_busy, io_done, io_tmo;
  logic ack_en = 1'b1, idle_en = 1'b1, stat_en = 1'b1;
  int n_tests = 0, n_fail = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pd_seq #(.TO_CYCLES(64)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack_i), .idle_i(idle_i),
    .pwr_stat_i(pwr_stat_i), .pwr_en_o(pwr_en_o), .idle_req_o(idle_req_o),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o));

  pd_seq #(.TO_CYCLES(64), .HAS_STATUS(1'b0)) u_dut_io (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(1'b0), .reg_addr_i(4'h4),
    .reg_wdata_i(32'd0), .reg_rdata_o(io_rdata), .ack_i(1'b0), .idle_i(io_idle),
    .pwr_stat_i(1'b0), .pwr_en_o(io_pwr), .idle_req_o(io_req),
    .busy_o(io_busy), .done_o(io_done), .timeout_o(io_tmo));

  // island model
  always @(negedge clk) begin
    if (ack_en)  ack_i      <= idle_req_o;
    if (idle_en) idle_i     <= ack_i;
    if (stat_en) pwr_stat_i <= !pwr_en_o;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(string tag, int ev);
    exp_q.push_back(ev);
    tag_q.push_back(tag);
  endtask

  task automatic take(int ev);
    if (exp_q.size() == 0) chk("unexpected event", ev, 0);
    else chk(tag_q.pop_front(), ev, exp_q.pop_front());
  endtask

  // monitor
  logic p_pwr = 1'b1, p_req = 1'b0, p_done = 1'b0, p_tmo = 1'b0;
  always @(negedge clk) if (rst_ni) begin
    if (idle_req_o && !p_req) take(EV_REQ_UP);
    if (!idle_req_o && p_req) take(EV_REQ_DN);
    if (!pwr_en_o && p_pwr)   take(EV_PWR_DN);
    if (pwr_en_o && !p_pwr)   take(EV_PWR_UP);
    if (done_o && !p_done)    take(EV_DONE);
    if (timeout_o && !p_tmo)  take(EV_TMO);
    p_pwr = pwr_en_o; p_req = idle_req_o; p_done = done_o; p_tmo = timeout_o;
  end

  task automatic wr_now(logic [3:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 400; i++) begin
      if (done_o || timeout_o) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_tb();
    chk("R1 scoreboard drained", 32'(exp_q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=expired exp=finished");
    finish_tb();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R10 reset pwr_en", pwr_en_o, 1);
    chk("R10 reset idle_req", idle_req_o, 0);
    chk("R10 reset busy/done/tmo", {busy_o, done_o, timeout_o}, 0);
    rd(4'h4, d); chk("R3 reset status", d, 32'h2);
    rd(4'h8, d); chk("R7 down count reset", d, 24);
    rd(4'hC, d); chk("R7 up count reset", d, 24);

    // power off, default settle
    push("R1 req up", EV_REQ_UP); push("R1 pwr down", EV_PWR_DN); push("R1 done", EV_DONE);
    wr(4'h0, OFF_CMD);
    chk("R10 busy after cmd", busy_o, 1);
    for (int i = 0; i < 400 && pwr_en_o; i++) @(negedge clk);
    n = 0;
    while (!done_o && n < 400) begin @(negedge clk); n++; end
    chk("R7 down settle gap", n, 26);
    @(negedge clk);
    chk("R10 done one cycle", done_o, 0);
    rd(4'h4, d); chk("R3 status off", d, 32'h0);

    // unmasked write
    wr(4'h0, 32'h0000_0001);
    repeat (20) @(negedge clk);
    rd(4'h0, d); chk("R5 target kept", d, 0);
    chk("R5 no power change", {pwr_en_o, busy_o}, 0);

    // same-state command
    push("R8 done only", EV_DONE);
    wr(4'h0, OFF_CMD);
    wait_end(); @(negedge clk);
    chk("R8 outputs unchanged", {pwr_en_o, idle_req_o}, 2'b01);

    // power on, programmed settle
    wr(4'hC, 32'd10);
    rd(4'hC, d); chk("R7 up count write", d, 10);
    push("R2 pwr up", EV_PWR_UP); push("R2 req down", EV_REQ_DN); push("R2 done", EV_DONE);
    wr(4'h0, ON_CMD);
    for (int i = 0; i < 400 && !pwr_en_o; i++) @(negedge clk);
    n = 0;
    while (idle_req_o && n < 400) begin @(negedge clk); n++; end
    chk("R7 up settle gap", n, 12);
    wait_end(); @(negedge clk);
    rd(4'h4, d); chk("R2 status on", d, 32'h2);
    rd(4'h0, d); chk("R5 target readback", d, 1);

    // command while busy
    push("R9 req up", EV_REQ_UP); push("R9 pwr down", EV_PWR_DN); push("R9 done", EV_DONE);
    wr(4'h0, OFF_CMD);
    wr(4'h0, ON_CMD);
    wait_end(); repeat (60) @(negedge clk);
    rd(4'h4, d); chk("R9 overrun set, off", d, 32'h4);
    wr(4'h0, 32'h0000_0002);
    rd(4'h4, d); chk("R5 clear needs mask", d, 32'h4);
    wr(4'h0, 32'h0002_0002);
    rd(4'h4, d); chk("R9 overrun cleared", d, 32'h0);

    // command in the done cycle
    push("R9 pwr up", EV_PWR_UP); push("R9 req down", EV_REQ_DN); push("R9 done", EV_DONE);
    wr(4'h0, ON_CMD);
    wait_end();
    wr_now(4'h0, OFF_CMD);
    repeat (60) @(negedge clk);
    rd(4'h4, d); chk("R9 done-cycle cmd refused", d, 32'h6);
    wr(4'h0, 32'h0002_0002);

    // ack timeout
    ack_en = 1'b0;
    push("R6 req up", EV_REQ_UP); push("R6 ack timeout", EV_TMO);
    wr(4'h0, OFF_CMD);
    wait_end(); @(negedge clk);
    chk("R6 timeout held", timeout_o, 1);
    rd(4'h4, d); chk("R6 ack code", d, 32'h12);
    ack_en = 1'b1;
    push("R6 retry pwr down", EV_PWR_DN); push("R6 retry done", EV_DONE);
    wr(4'h0, OFF_CMD);
    wait_end(); @(negedge clk);
    rd(4'h4, d); chk("R6 code cleared", d, 32'h0);

    // power status timeout
    stat_en = 1'b0;
    push("R6 pwr up", EV_PWR_UP); push("R6 pwr timeout", EV_TMO);
    wr(4'h0, ON_CMD);
    wait_end(); @(negedge clk);
    rd(4'h4, d); chk("R6 power code", d, 32'h30);
    stat_en = 1'b1;
    repeat (4) @(negedge clk);
    push("R8 recover done", EV_DONE);
    wr(4'h0, ON_CMD);
    wait_end(); @(negedge clk);
    chk("R6 timeout cleared", timeout_o, 0);
    push("R1 pwr down", EV_PWR_DN); push("R1 done", EV_DONE);
    wr(4'h0, OFF_CMD);
    wait_end();
    push("R2 pwr up", EV_PWR_UP); push("R2 req down", EV_REQ_DN); push("R2 done", EV_DONE);
    wr(4'h0, ON_CMD);
    wait_end(); repeat (4) @(negedge clk);

    // idle timeout
    idle_en = 1'b0;
    push("R6 req up", EV_REQ_UP); push("R6 idle timeout", EV_TMO);
    wr(4'h0, OFF_CMD);
    wait_end(); @(negedge clk);
    rd(4'h4, d); chk("R6 idle code", d, 32'h22);
    idle_en = 1'b1;
    push("R6 retry pwr down", EV_PWR_DN); push("R6 retry done", EV_DONE);
    wr(4'h0, OFF_CMD);
    wait_end(); @(negedge clk);
    rd(4'h4, d); chk("R3 final off", d, 32'h0);

    // idle-only variant
    #1 chk("R4 idle low reads on", io_rdata[1], 1);
    io_idle = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R4 idle high reads off", io_rdata[1], 0);
    repeat (5) @(negedge clk);
    finish_tb();
  end
endmodule